// File: doc/BRIEF.md
# 16-bit Address Linearizer with Limit Check

This block turns a 16-bit memory operand into a linear address. The caller provides the mode and r/m fields of the operand byte, a displacement that has already been extended to 16 bits, the four 16-bit address registers (BX, BP, SI, DI), and the segment context. The segment context is a selector, a descriptor base, a raw 20-bit limit with a granularity flag, and two mode flags. The block looks up the register pair that the r/m field selects. It forms the 16-bit effective address and checks it against the expanded limit when protection applies. It then adds the segment base.

Protected operation is selected when `prot_mode` is high and `v86_mode` is low. In that case the descriptor base is added over the full 32-bit width. Segment-shift operation is selected when `v86_mode` is high or `prot_mode` is low. In that case the base is the selector times 16 and the sum wraps at 20 bits. The block also reports the register that decides the default segment, so a neighbouring unit can pick the segment for the next access.

The result is registered one clock after an input strobe. A faulting access returns an all-ones address.

Top module: `lin16_linearizer`

## Requirements
- R1: For r/m values 0 to 7 the first register is BX, BX, BP, BP, SI, DI, BP, BX. The second register is SI, DI, SI, DI for r/m 0 to 3 and is absent for r/m 4 to 7. With mod 1 or 2 the effective address is (first + second + displacement) mod 2^16.
- R2: With mod 0 and r/m 6 no register is used, the effective address equals the displacement, and `seg_src` is 0 (none).
- R3: With mod 0 and any r/m other than 6 the displacement is not added, and changing it has no effect on the result.
- R4: `seg_src` names the first register of the pair, encoded as none=0, BX=1, BP=2, SI=3, DI=4. The second register never affects it.
- R5: With `seg_gran`=1 the effective limit is (limit << 12) + 0xFFF. With `seg_gran`=0 the effective limit is the raw limit.
- R6: In protected operation, an effective address greater than the effective limit faults. An address equal to the limit does not fault.
- R7: In protected operation, a null selector (bits 15:2 all zero) faults.
- R8: In protected operation without a fault, `lin_addr` = (`seg_base` + effective address) mod 2^32.
- R9: In segment-shift operation, `lin_addr` = ((`seg_sel` << 4) + effective address) mod 2^20 with bits 31:20 zero. No limit check and no null-selector check is made, and `seg_base` is ignored.
- R10: A mod value of 3 names a register, not memory, and always faults.
- R11: When `fault` is 1, `lin_addr` is all ones, and `seg_src` is still reported.
- R12: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. Outputs hold their values while `in_valid` is low, and reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| addr_mod | input | 2 | Mode field of the operand byte |
| addr_rm | input | 3 | r/m field of the operand byte |
| disp | input | 16 | Extended displacement |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_sel | input | 16 | Segment selector |
| seg_base | input | 32 | Descriptor base (protected operation) |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | Limit granularity, 1 = 4 KiB units |
| prot_mode | input | 1 | Protected operation enable |
| v86_mode | input | 1 | Virtual-8086 operation, overrides `prot_mode` |
| out_valid | output | 1 | Result strobe |
| lin_addr | output | 32 | Linear address, all ones on fault |
| fault | output | 1 | Access fault |
| seg_src | output | 3 | Segment-deciding register code |

## Verification
Several rules are checked on every cycle by assertions:

- the one-cycle strobe timing;
- the all-ones address on a fault;
- the fault on register-form operands and on null selectors;
- the absence of limit faults and of high address bits in segment-shift operation;
- the "none" code for displacement-only forms.

Some behaviour can only be shown by the bench's directed scenarios, because it depends on actual data values. This covers the exact register-pair sums and their 16-bit wrap, the equal-versus-one-above limit boundary, the granularity expansion, the 20-bit wrap of a shifted selector, and the fact that the displacement and the descriptor base are ignored where they should be.

// File: rtl/lin16_pkg.sv
`timescale 1ns/1ps
package lin16_pkg;

  // Code of the register that decides the default segment.
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BX   = 3'd1,
    SRC_BP   = 3'd2,
    SRC_SI   = 3'd3,
    SRC_DI   = 3'd4
  } seg_src_e;

  localparam int SRC_W = 3;

  // First register of the 16-bit pair table.
  function automatic seg_src_e pair_first(input logic [2:0] rm);
    case (rm)
      3'd0, 3'd1, 3'd7: pair_first = SRC_BX;
      3'd2, 3'd3, 3'd6: pair_first = SRC_BP;
      3'd4:             pair_first = SRC_SI;
      default:          pair_first = SRC_DI;
    endcase
  endfunction

  // Second register of the pair table; absent in the upper half.
  function automatic seg_src_e pair_second(input logic [2:0] rm);
    if (rm[2])      pair_second = SRC_NONE;
    else if (rm[0]) pair_second = SRC_DI;
    else            pair_second = SRC_SI;
  endfunction

endpackage

// File: rtl/lin16_ea_decode.sv
`timescale 1ns/1ps
module lin16_ea_decode
  import lin16_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    addr_mod,
  input  logic [2:0]    addr_rm,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  output logic [AW-1:0] ea,
  output seg_src_e      first_src,
  output logic          reg_form
);

  localparam int NSLOT = 2;

  function automatic logic [AW-1:0] reg_value(
    input seg_src_e src,
    input logic [AW-1:0] bx, input logic [AW-1:0] bp,
    input logic [AW-1:0] si, input logic [AW-1:0] di);
    case (src)
      SRC_BX:  reg_value = bx;
      SRC_BP:  reg_value = bp;
      SRC_SI:  reg_value = si;
      SRC_DI:  reg_value = di;
      default: reg_value = '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] wrap_sum3(
    input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] c);
    wrap_sum3 = a + b + c;
  endfunction

  logic          disp_only;
  logic          use_disp;
  seg_src_e      slot_src [NSLOT];
  logic [AW-1:0] slot_val [NSLOT];

  assign disp_only = (addr_mod == 2'd0) && (addr_rm == 3'd6);
  assign use_disp  = (addr_mod != 2'd0) || disp_only;
  assign reg_form  = (addr_mod == 2'd3);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == 0) begin : g_first
      assign slot_src[s] = disp_only ? SRC_NONE : pair_first(addr_rm);
    end else begin : g_second
      assign slot_src[s] = disp_only ? SRC_NONE : pair_second(addr_rm);
    end
    assign slot_val[s] = reg_value(slot_src[s], reg_bx, reg_bp, reg_si, reg_di);
  end

  assign first_src = slot_src[0];
  assign ea = wrap_sum3(slot_val[0], slot_val[1], use_disp ? disp : '0);

endmodule

// File: rtl/lin16_limit_chk.sv
`timescale 1ns/1ps
module lin16_limit_chk #(
  parameter int AW      = 16,
  parameter int LIM_W   = 20,
  parameter int GRAN_SH = 12
) (
  input  logic [AW-1:0]    ea,
  input  logic [LIM_W-1:0] limit_raw,
  input  logic             gran,
  output logic             over
);

  localparam int CW = LIM_W + GRAN_SH;

  function automatic logic [CW-1:0] expand_limit(
    input logic [LIM_W-1:0] raw, input logic g);
    if (g) expand_limit = {raw, {GRAN_SH{1'b1}}};
    else   expand_limit = {{GRAN_SH{1'b0}}, raw};
  endfunction

  logic [CW-1:0] eff_limit;
  logic [CW-1:0] ea_wide;

  assign eff_limit = expand_limit(limit_raw, gran);
  assign ea_wide   = CW'(ea);
  assign over      = ea_wide > eff_limit;

endmodule

// File: rtl/lin16_base_add.sv
`timescale 1ns/1ps
module lin16_base_add #(
  parameter int AW     = 16,
  parameter int LIN_W  = 32,
  parameter int SEL_W  = 16,
  parameter int SHIFT  = 4,
  parameter int WRAP_W = 20
) (
  input  logic [AW-1:0]    ea,
  input  logic [LIN_W-1:0] seg_base,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             shift_mode,
  output logic [LIN_W-1:0] lin
);

  function automatic logic [WRAP_W-1:0] shifted_sum(
    input logic [SEL_W-1:0] sel, input logic [AW-1:0] off);
    logic [WRAP_W-1:0] b;
    b = WRAP_W'({sel, {SHIFT{1'b0}}});
    shifted_sum = b + WRAP_W'(off);
  endfunction

  function automatic logic [LIN_W-1:0] based_sum(
    input logic [LIN_W-1:0] base, input logic [AW-1:0] off);
    based_sum = base + LIN_W'(off);
  endfunction

  logic [WRAP_W-1:0] lin_shift;
  logic [LIN_W-1:0]  lin_based;

  assign lin_shift = shifted_sum(seg_sel, ea);
  assign lin_based = based_sum(seg_base, ea);
  assign lin       = shift_mode ? LIN_W'(lin_shift) : lin_based;

endmodule

// File: rtl/lin16_linearizer.sv
`timescale 1ns/1ps
module lin16_linearizer
  import lin16_pkg::*;
#(
  parameter int AW      = 16,
  parameter int LIN_W   = 32,
  parameter int SEL_W   = 16,
  parameter int LIM_W   = 20,
  parameter int GRAN_SH = 12,
  parameter int SHIFT   = 4,
  parameter int WRAP_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       addr_mod,
  input  logic [2:0]       addr_rm,
  input  logic [AW-1:0]    disp,
  input  logic [AW-1:0]    reg_bx,
  input  logic [AW-1:0]    reg_bp,
  input  logic [AW-1:0]    reg_si,
  input  logic [AW-1:0]    reg_di,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic [LIN_W-1:0] seg_base,
  input  logic [LIM_W-1:0] seg_limit,
  input  logic             seg_gran,
  input  logic             prot_mode,
  input  logic             v86_mode,
  output logic             out_valid,
  output logic [LIN_W-1:0] lin_addr,
  output logic             fault,
  output logic [SRC_W-1:0] seg_src
);

  // Named internal events.
  logic [AW-1:0]    ea_w;
  seg_src_e         src_w;
  logic             regform_w;
  logic             over_w;
  logic             prot_path_w;
  logic             null_sel_w;
  logic             fault_w;
  logic [LIN_W-1:0] lin_w;

  lin16_ea_decode #(.AW(AW)) u_dec (
    .addr_mod  (addr_mod),
    .addr_rm   (addr_rm),
    .disp      (disp),
    .reg_bx    (reg_bx),
    .reg_bp    (reg_bp),
    .reg_si    (reg_si),
    .reg_di    (reg_di),
    .ea        (ea_w),
    .first_src (src_w),
    .reg_form  (regform_w)
  );

  lin16_limit_chk #(.AW(AW), .LIM_W(LIM_W), .GRAN_SH(GRAN_SH)) u_lim (
    .ea        (ea_w),
    .limit_raw (seg_limit),
    .gran      (seg_gran),
    .over      (over_w)
  );

  lin16_base_add #(.AW(AW), .LIN_W(LIN_W), .SEL_W(SEL_W),
                   .SHIFT(SHIFT), .WRAP_W(WRAP_W)) u_add (
    .ea         (ea_w),
    .seg_base   (seg_base),
    .seg_sel    (seg_sel),
    .shift_mode (~prot_path_w),
    .lin        (lin_w)
  );

  assign prot_path_w = prot_mode & ~v86_mode;
  assign null_sel_w  = (seg_sel[SEL_W-1:2] == '0);
  assign fault_w     = regform_w | (prot_path_w & (null_sel_w | over_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
      fault     <= 1'b0;
      seg_src   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fault    <= fault_w;
        lin_addr <= fault_w ? '1 : lin_w;
        seg_src  <= src_w;
      end
    end
  end

endmodule

// File: rtl/lin16_linearizer_chk.sv
`timescale 1ns/1ps
module lin16_linearizer_chk #(
  parameter int LIN_W  = 32,
  parameter int SEL_W  = 16,
  parameter int WRAP_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       addr_mod,
  input logic [2:0]       addr_rm,
  input logic [SEL_W-1:0] seg_sel,
  input logic             prot_mode,
  input logic             v86_mode,
  input logic             over_w,
  input logic             out_valid,
  input logic [LIN_W-1:0] lin_addr,
  input logic             fault,
  input logic [2:0]       seg_src
);

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                           // R12
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                         // R12
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lin_addr) && $stable(fault));                // R12
  AST_FAULT_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault) |-> (lin_addr == {LIN_W{1'b1}}));             // R11
  AST_REGFORM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_mod == 2'd3) |=> fault);                         // R10
  AST_DISP_ONLY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_mod == 2'd0 && addr_rm == 3'd6) |=> (seg_src == 3'd0)); // R2
  AST_NULL_SEL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prot_mode && !v86_mode && seg_sel[SEL_W-1:2] == '0) |=> fault); // R7
  AST_OVER_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prot_mode && !v86_mode && over_w) |=> fault);         // R6
  AST_SHIFT_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (v86_mode || !prot_mode) && addr_mod != 2'd3) |=> !fault); // R9
  AST_SHIFT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (v86_mode || !prot_mode) && addr_mod != 2'd3)
      |=> (lin_addr[LIN_W-1:WRAP_W] == '0));                           // R9

endmodule

bind lin16_linearizer lin16_linearizer_chk #(
  .LIN_W(LIN_W), .SEL_W(SEL_W), .WRAP_W(WRAP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .addr_mod  (addr_mod),
  .addr_rm   (addr_rm),
  .seg_sel   (seg_sel),
  .prot_mode (prot_mode),
  .v86_mode  (v86_mode),
  .over_w    (over_w),
  .out_valid (out_valid),
  .lin_addr  (lin_addr),
  .fault     (fault),
  .seg_src   (seg_src)
);

// File: tb/sim_lin16_linearizer.sv
`timescale 1ns/1ps
module sim_lin16_linearizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  addr_mod = '0;
  logic [2:0]  addr_rm = '0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_sel = '0;
  logic [31:0] seg_base = '0;
  logic [19:0] seg_limit = '0;
  logic        seg_gran = 1'b0;
  logic        prot_mode = 1'b0;
  logic        v86_mode = 1'b0;
  logic        out_valid;
  logic [31:0] lin_addr;
  logic        fault;
  logic [2:0]  seg_src;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lin16_linearizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .addr_mod(addr_mod), .addr_rm(addr_rm), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_sel(seg_sel), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_gran(seg_gran), .prot_mode(prot_mode), .v86_mode(v86_mode),
    .out_valid(out_valid), .lin_addr(lin_addr), .fault(fault), .seg_src(seg_src)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  // Independent reference: written as explicit per-r/m sums.
  function automatic logic [15:0] ref_ea();
    logic [15:0] d;
    d = (addr_mod == 2'd0) ? 16'h0 : disp;
    case (addr_rm)
      3'd0: ref_ea = reg_bx + reg_si + d;
      3'd1: ref_ea = reg_bx + reg_di + d;
      3'd2: ref_ea = reg_bp + reg_si + d;
      3'd3: ref_ea = reg_bp + reg_di + d;
      3'd4: ref_ea = reg_si + d;
      3'd5: ref_ea = reg_di + d;
      3'd6: ref_ea = (addr_mod == 2'd0) ? disp : reg_bp + d;
      default: ref_ea = reg_bx + d;
    endcase
  endfunction

  function automatic logic [2:0] ref_src();
    if (addr_mod == 2'd0 && addr_rm == 3'd6) ref_src = 3'd0;
    else case (addr_rm)
      3'd0, 3'd1, 3'd7: ref_src = 3'd1;
      3'd2, 3'd3, 3'd6: ref_src = 3'd2;
      3'd4: ref_src = 3'd3;
      default: ref_src = 3'd4;
    endcase
  endfunction

  function automatic logic ref_fault();
    logic [31:0] lim;
    lim = seg_gran ? {seg_limit, 12'hFFF} : {12'h0, seg_limit};
    if (addr_mod == 2'd3) ref_fault = 1'b1;
    else if (v86_mode || !prot_mode) ref_fault = 1'b0;
    else ref_fault = (seg_sel[15:2] == 14'd0) || ({16'h0, ref_ea()} > lim);
  endfunction

  function automatic logic [31:0] ref_lin();
    logic [31:0] full;
    if (ref_fault()) ref_lin = 32'hFFFF_FFFF;
    else if (v86_mode || !prot_mode) begin
      full = {12'h0, seg_sel, 4'h0} + {16'h0, ref_ea()};
      ref_lin = {12'h0, full[19:0]};
    end else ref_lin = seg_base + {16'h0, ref_ea()};
  endfunction

  // Strobe once at a negedge, sample at the following negedge.
  task automatic apply(input string rq);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(rq, "out_valid", {31'h0, out_valid}, 32'h1);
    check(rq, "fault", {31'h0, fault}, {31'h0, ref_fault()});
    check(rq, "lin_addr", lin_addr, ref_lin());
    if (addr_mod != 2'd3) check(rq, "seg_src", {29'h0, seg_src}, {29'h0, ref_src()});
  endtask

  task automatic set_prot(input logic [31:0] b, input logic [19:0] lim, input logic g);
    prot_mode = 1'b1; v86_mode = 1'b0;
    seg_sel = 16'h0010; seg_base = b; seg_limit = lim; seg_gran = g;
  endtask

  task automatic t_reset();
    check("R12", "reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R12", "reset lin_addr", lin_addr, 32'h0);
    check("R12", "reset fault", {31'h0, fault}, 32'h0);
  endtask

  task automatic t_table();
    set_prot(32'h0001_0000, 20'hFFFFF, 1'b0);
    reg_bx = 16'h1000; reg_bp = 16'h0200; reg_si = 16'h0030; reg_di = 16'h0004;
    disp = 16'h0500;
    for (int r = 0; r < 8; r++) begin
      addr_mod = 2'd2; addr_rm = r[2:0];
      apply("R1");
      addr_mod = 2'd1; disp = 16'hFFF0;
      apply("R4");
      disp = 16'h0500;
    end
  endtask

  task automatic t_disp_only();
    set_prot(32'h0000_2000, 20'hFFFFF, 1'b0);
    addr_mod = 2'd0; addr_rm = 3'd6; disp = 16'h4321; reg_bp = 16'h7777;
    apply("R2");
  endtask

  task automatic t_no_disp();
    set_prot(32'h0000_0000, 20'hFFFFF, 1'b0);
    addr_mod = 2'd0; addr_rm = 3'd0; reg_bx = 16'h0100; reg_si = 16'h0020;
    disp = 16'h0000; apply("R3");
    disp = 16'h5A5A; apply("R3");
    check("R3", "disp ignored", lin_addr, 32'h0000_0120);
  endtask

  task automatic t_wrap16();
    set_prot(32'h0000_0000, 20'hFFFFF, 1'b0);
    addr_mod = 2'd2; addr_rm = 3'd3; reg_bp = 16'hFFF0; reg_di = 16'h0020; disp = 16'h0010;
    apply("R1");
    check("R1", "16-bit wrap", lin_addr, 32'h0000_0020);
  endtask

  task automatic t_limit();
    addr_mod = 2'd0; addr_rm = 3'd0; reg_bx = 16'h1000; reg_si = 16'h0234;
    set_prot(32'hFFFF_F000, 20'h01234, 1'b0);
    apply("R6");
    check("R8", "base wrap 32", lin_addr, 32'h0000_0234);
    seg_limit = 20'h01233; apply("R6");
    check("R11", "fault all ones", lin_addr, 32'hFFFF_FFFF);
    check("R11", "src on fault", {29'h0, seg_src}, 32'h1);
  endtask

  task automatic t_gran();
    addr_mod = 2'd0; addr_rm = 3'd4;
    set_prot(32'h0000_0000, 20'h00000, 1'b1);
    reg_si = 16'h0FFF; apply("R5");
    reg_si = 16'h1000; apply("R5");
    seg_limit = 20'h00001; apply("R5");
  endtask

  task automatic t_null();
    set_prot(32'h0000_0000, 20'hFFFFF, 1'b0);
    addr_mod = 2'd1; addr_rm = 3'd5; reg_di = 16'h0010; disp = 16'h0001;
    seg_sel = 16'h0003; apply("R7");
    seg_sel = 16'h0004; apply("R7");
  endtask

  task automatic t_v86();
    prot_mode = 1'b1; v86_mode = 1'b1;
    seg_base = 32'hDEAD_0000; seg_limit = 20'h0; seg_gran = 1'b0;
    addr_mod = 2'd1; addr_rm = 3'd7; reg_bx = 16'h0008; disp = 16'h0008;
    seg_sel = 16'hFFFF; apply("R9");
    check("R9", "20-bit wrap", lin_addr, 32'h0000_0000);
    seg_sel = 16'h0000; apply("R9");
    prot_mode = 1'b0; v86_mode = 1'b0; seg_sel = 16'h1234;
    apply("R9");
  endtask

  task automatic t_regform();
    set_prot(32'h0, 20'hFFFFF, 1'b0);
    addr_mod = 2'd3; addr_rm = 3'd2; apply("R10");
    v86_mode = 1'b1; apply("R10");
  endtask

  task automatic t_hold();
    logic [31:0] prev;
    prev = lin_addr;
    addr_mod = 2'd2; addr_rm = 3'd1; reg_bx = 16'h1111; seg_sel = 16'h2222;
    repeat (3) @(negedge clk);
    check("R12", "idle out_valid", {31'h0, out_valid}, 32'h0);
    check("R12", "idle hold", lin_addr, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_table();
    t_disp_only();
    t_no_disp();
    t_wrap16();
    t_limit();
    t_gran();
    t_null();
    t_v86();
    t_regform();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule